// File: doc/BRIEF.md
# Global 64-bit Compare Timer

This block is a memory-mapped system timer. It holds a 64-bit up-counter that advances once per clock while running, and one 64-bit comparator. When the comparator is enabled and its value equals the counter, an interrupt status bit is latched. An optional auto-increment mode adds a stored 32-bit step to the comparator on every match, so that events repeat at a fixed period without software reloading the comparator.

Software reaches every register through a plain 32-bit word port: address, write strobe, write data, and a registered read data word. Each write to the counter halves, to the comparator words, to the step or to the control register is later acknowledged by its own sticky write-status bit. The acknowledge appears a fixed, parameterised number of cycles after the write, which models a synchronisation delay. Software polls the bit and clears it by writing 1. Because the counter halves are read one at a time, software detects a carry between them by reading the upper half, then the lower, then the upper again.

Top module: `gcmp_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq` is low.
- R2: While control bit 8 (run) is set, the counter increases by exactly 1 per clock, with the carry from bit 31 going into bit 32. While run is clear, the counter holds its value.
- R3: A write to 0x100 loads counter bits 31:0, and a write to 0x104 loads bits 63:32. In the cycle of a load no count step happens.
- R4: The write-acknowledge bits are: at 0x110, bit 0 for a write to 0x100 and bit 1 for a write to 0x104; at 0x24C, bits 0, 1 and 2 for writes to 0x200, 0x204 and 0x208, and bit 16 for a write to 0x240. Each bit sets exactly ACK_DLY cycles after its write, even when the written value equals the old one.
- R5: Writing 1 to an acknowledge bit position clears that bit. Writing 0 to a position leaves that bit unchanged.
- R6: When control bit 0 (compare enable) is set and the counter equals the comparator (0x200 low, 0x204 high), bit 0 of 0x244 sets on the next cycle. The bit is sticky. Writing 1 to it clears it, and writing 0 to it has no effect.
- R7: `irq` is the AND of status bit 0 of 0x244 and enable bit 0 of 0x248, registered, so it follows either bit one cycle later. With the counter starting at 0 and the comparator at C, `irq` first rises C+2 clocks after the control write that starts the counter.
- R8: With control bit 1 (auto-increment) set, every match adds the value at 0x208 to the comparator. With bit 1 clear, the comparator keeps its value after a match.
- R9: Read data is registered: a read returns the register selected by the address one cycle earlier. Unmapped addresses read 0. The control register reads back only bits 8, 1 and 0.
- R10: While compare enable is clear, no match sets the status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker assumes that reset is held for at least one clock, and that a comparator word write and a match do not need to agree in the same cycle. When both occur, the write wins, and the auto-increment property excludes those cycles. The stimulus writes the comparator only while compare enable is clear. It loads the counter only while it is stopped, except in the one test that checks load priority. Because of this, every match that the bench predicts comes from a counter that starts at zero and runs without interruption.

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 64;
  localparam int HI_W   = CNT_W - WORD_W;

  // register offsets (software decodes these)
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'h100;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'h104;
  localparam logic [ADDR_W-1:0] A_CNT_ACK = 12'h110;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h200;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h204;
  localparam logic [ADDR_W-1:0] A_CMP_INC = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h240;
  localparam logic [ADDR_W-1:0] A_IST     = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN     = 12'h248;
  localparam logic [ADDR_W-1:0] A_GACK    = 12'h24C;

  // control and acknowledge bit positions
  localparam int B_RUN      = 8;
  localparam int B_CMPEN    = 0;
  localparam int B_AUTO     = 1;
  localparam int B_ACK_CTRL = 16;

  localparam int CNT_ACK_N = 2;
  localparam int GL_ACK_N  = 4;
endpackage

// File: rtl/gcmp_counter.sv
module gcmp_counter #(
  parameter int CW = 64,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [WW-1:0] wdata,
  output logic [CW-1:0] cnt
);
  localparam int HW = CW - WW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_lo || ld_hi) begin
      // a load wins over the count step in the same cycle
      if (ld_lo) cnt[WW-1:0] <= wdata;
      if (ld_hi) cnt[CW-1:WW] <= wdata[HW-1:0];
    end else if (run) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/gcmp_compare.sv
module gcmp_compare #(
  parameter int CW = 64,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          auto_inc,
  input  logic [CW-1:0] cnt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_inc,
  input  logic [WW-1:0] wdata,
  output logic [CW-1:0] cmp,
  output logic [WW-1:0] incr,
  output logic          match
);
  localparam int HW = CW - WW;

  assign match = en && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cmp[WW-1:0] <= wdata;
      if (wr_hi) cmp[CW-1:WW] <= wdata[HW-1:0];
    end else if (match && auto_inc) begin
      cmp <= cmp + CW'(incr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         incr <= '0;
    else if (wr_inc) incr <= wdata;
  end
endmodule

// File: rtl/gcmp_wack.sv
module gcmp_wack #(
  parameter int N   = 4,
  parameter int DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] stat
);
  logic [N-1:0] pipe [DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DLY; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= ev;
      for (int i = 1; i < DLY; i++) pipe[i] <= pipe[i-1];
    end
  end

  // a bit arriving from the delay line wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~(clr_we ? clr_mask : '0)) | pipe[DLY-1];
  end
endmodule

// File: rtl/gcmp_timer.sv
module gcmp_timer
  import gcmp_pkg::*;
#(
  parameter int ACK_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ack;
  logic wr_cmp_lo, wr_cmp_hi, wr_cmp_inc;
  logic wr_ctrl, wr_ist, wr_ien, wr_gack;

  always_comb begin
    wr_cnt_lo  = bus_wr && (bus_addr == A_CNT_LO);
    wr_cnt_hi  = bus_wr && (bus_addr == A_CNT_HI);
    wr_cnt_ack = bus_wr && (bus_addr == A_CNT_ACK);
    wr_cmp_lo  = bus_wr && (bus_addr == A_CMP_LO);
    wr_cmp_hi  = bus_wr && (bus_addr == A_CMP_HI);
    wr_cmp_inc = bus_wr && (bus_addr == A_CMP_INC);
    wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
    wr_ist     = bus_wr && (bus_addr == A_IST);
    wr_ien     = bus_wr && (bus_addr == A_IEN);
    wr_gack    = bus_wr && (bus_addr == A_GACK);
  end

  logic run_q, cmpen_q, auto_q, ist_q, ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cmpen_q <= 1'b0;
      auto_q  <= 1'b0;
    end else if (wr_ctrl) begin
      run_q   <= bus_wdata[B_RUN];
      cmpen_q <= bus_wdata[B_CMPEN];
      auto_q  <= bus_wdata[B_AUTO];
    end
  end

  logic [CNT_W-1:0]  cnt, cmp;
  logic [WORD_W-1:0] incr;
  logic              match;

  gcmp_counter #(.CW(CNT_W), .WW(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q),
    .ld_lo(wr_cnt_lo), .ld_hi(wr_cnt_hi), .wdata(bus_wdata), .cnt(cnt)
  );

  gcmp_compare #(.CW(CNT_W), .WW(WORD_W)) u_cmp (
    .clk(clk), .rst(rst), .en(cmpen_q), .auto_inc(auto_q), .cnt(cnt),
    .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wr_inc(wr_cmp_inc),
    .wdata(bus_wdata), .cmp(cmp), .incr(incr), .match(match)
  );

  // interrupt status, enable and the registered request
  always_ff @(posedge clk) begin
    if (rst) begin
      ist_q <= 1'b0;
      ien_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (match)                      ist_q <= 1'b1;
      else if (wr_ist && bus_wdata[0]) ist_q <= 1'b0;
      if (wr_ien) ien_q <= bus_wdata[0];
      irq <= ist_q & ien_q;
    end
  end

  logic [CNT_ACK_N-1:0] cnt_ack;
  logic [GL_ACK_N-1:0]  gl_ack;

  gcmp_wack #(.N(CNT_ACK_N), .DLY(ACK_DLY)) u_cnt_ack (
    .clk(clk), .rst(rst), .ev({wr_cnt_hi, wr_cnt_lo}),
    .clr_we(wr_cnt_ack), .clr_mask(bus_wdata[CNT_ACK_N-1:0]), .stat(cnt_ack)
  );

  gcmp_wack #(.N(GL_ACK_N), .DLY(ACK_DLY)) u_gl_ack (
    .clk(clk), .rst(rst), .ev({wr_ctrl, wr_cmp_inc, wr_cmp_hi, wr_cmp_lo}),
    .clr_we(wr_gack), .clr_mask({bus_wdata[B_ACK_CTRL], bus_wdata[2:0]}),
    .stat(gl_ack)
  );

  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    case (bus_addr)
      A_CNT_LO:  rd_mux = cnt[WORD_W-1:0];
      A_CNT_HI:  rd_mux = WORD_W'(cnt[CNT_W-1:WORD_W]);
      A_CNT_ACK: rd_mux = WORD_W'(cnt_ack);
      A_CMP_LO:  rd_mux = cmp[WORD_W-1:0];
      A_CMP_HI:  rd_mux = WORD_W'(cmp[CNT_W-1:WORD_W]);
      A_CMP_INC: rd_mux = incr;
      A_CTRL:    rd_mux = {23'd0, run_q, 6'd0, auto_q, cmpen_q};
      A_IST:     rd_mux = {31'd0, ist_q};
      A_IEN:     rd_mux = {31'd0, ien_q};
      A_GACK:    rd_mux = {15'd0, gl_ack[3], 13'd0, gl_ack[2:0]};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gcmp_timer_chk.sv
module gcmp_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        run,
  input logic        cmp_en,
  input logic        auto_en,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic [31:0] incr,
  input logic        ist,
  input logic        ien,
  input logic        ld_lo,
  input logic        ld_hi,
  input logic        cw_lo,
  input logic        cw_hi
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && cnt == 64'd0 && !run));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + 64'd1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

  // R6
  match_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cnt == cmp) |=> ist);

  // R10
  no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en && !ist) |=> !ist);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ist || !ien) |=> !irq);

  // R8
  auto_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && auto_en && cnt == cmp && !cw_lo && !cw_hi)
      |=> (cmp == $past(cmp) + {32'd0, $past(incr)}));
endmodule

bind gcmp_timer gcmp_timer_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .run(run_q), .cmp_en(cmpen_q),
  .auto_en(auto_q), .cnt(cnt), .cmp(cmp), .incr(incr), .ist(ist_q),
  .ien(ien_q), .ld_lo(wr_cnt_lo), .ld_hi(wr_cnt_hi),
  .cw_lo(wr_cmp_lo), .cw_hi(wr_cmp_hi)
);

// File: tb/gcmp_timer_bench.sv
module gcmp_timer_bench;
  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr_s = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done = 0;

  gcmp_timer #(.ACK_DLY(DLY)) u_gcmp_timer (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_s),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_s = 1'b1;
    @(posedge clk); #1;
    wr_s = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [11:0] regs [10];
    logic [11:0] wa [6];
    logic [11:0] aa [6];
    logic [31:0] am [6];
    int first;

    regs = '{12'h100, 12'h104, 12'h110, 12'h200, 12'h204,
             12'h208, 12'h240, 12'h244, 12'h248, 12'h24C};
    wa = '{12'h100, 12'h104, 12'h200, 12'h204, 12'h208, 12'h240};
    aa = '{12'h110, 12'h110, 12'h24C, 12'h24C, 12'h24C, 12'h24C};
    am = '{32'h1, 32'h2, 32'h1, 32'h2, 32'h4, 32'h1_0000};

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    chk("R1 irq after reset", irq, 0);
    foreach (regs[i]) begin
      rd(regs[i], d);
      chk($sformatf("R1 reg %h after reset", regs[i]), d, 0);
    end
    rd(12'h100, d);
    chk("R1 counter stopped", d, 0);

    // R4 / R5: acknowledge timing and write-1-to-clear
    foreach (wa[i]) begin
      wr(wa[i], 32'h0);
      for (int k = 0; k < DLY; k++) begin
        rd(aa[i], d);
        chk($sformatf("R4 ack %h early cycle %0d", wa[i], k), d, 0);
      end
      rd(aa[i], d);
      chk($sformatf("R4 ack %h set", wa[i]), d, am[i]);
      wr(aa[i], 32'h0);
      rd(aa[i], d);
      chk($sformatf("R5 ack %h kept on write 0", wa[i]), d, am[i]);
      wr(aa[i], am[i]);
      rd(aa[i], d);
      chk($sformatf("R5 ack %h cleared", wa[i]), d, 0);
    end

    // R3: load halves; R2: count with carry
    wr(12'h100, 32'hFFFF_FFFD);
    wr(12'h104, 32'h7);
    rd(12'h100, d); chk("R3 load low", d, 32'hFFFF_FFFD);
    rd(12'h104, d); chk("R3 load high", d, 32'h7);
    wr(12'h240, 32'h100);
    idle(5);
    wr(12'h240, 32'h0);
    rd(12'h100, d); chk("R2 carry low", d, 32'h3);
    rd(12'h104, d); chk("R2 carry high", d, 32'h8);
    rd(12'h100, d); chk("R2 hold when stopped", d, 32'h3);

    // R9 / R2: live reads step by one per cycle
    wr(12'h240, 32'h100);
    rd(12'h100, d);
    rd(12'h100, d2);
    chk("R9 live read step", d2, d + 1);

    // R3: load while running wins over the step
    wr(12'h100, 32'h50);
    wr(12'h240, 32'h0);
    rd(12'h100, d); chk("R3 load priority", d, 32'h51);
    rd(12'h104, d); chk("R3 high untouched", d, 32'h8);

    // R9: control readback mask and unmapped read
    wr(12'h240, 32'hFFFF_FEFF);
    rd(12'h240, d); chk("R9 control mask", d, 32'h3);
    wr(12'h240, 32'h0);
    rd(12'h0FC, d); chk("R9 unmapped", d, 0);

    // R10: disabled comparator never matches
    wr(12'h100, 0); wr(12'h104, 0);
    wr(12'h200, 10); wr(12'h204, 0);
    wr(12'h248, 1);
    wr(12'h240, 32'h100);
    idle(20);
    wr(12'h240, 32'h0);
    rd(12'h244, d); chk("R10 no status when disabled", d, 0);
    chk("R10 no irq when disabled", irq, 0);

    // R7: irq latency C+2
    wr(12'h100, 0);
    wr(12'h240, 32'h101);
    first = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      if (irq && first == 0) first = k;
    end
    wr(12'h240, 32'h0);
    chk("R7 irq latency", first, 12);
    rd(12'h244, d); chk("R6 status sticky", d, 1);
    wr(12'h244, 0);
    rd(12'h244, d); chk("R6 write 0 no clear", d, 1);
    wr(12'h248, 0);
    rd(12'h0FC, d); chk("R7 irq masked", irq, 0);
    wr(12'h248, 1);
    rd(12'h0FC, d); chk("R7 irq unmasked", irq, 1);
    wr(12'h244, 1);
    rd(12'h244, d); chk("R6 status cleared", d, 0);
    chk("R7 irq follows clear", irq, 0);

    // R8 / R6: sweep start value, step and mode
    for (int au = 0; au < 2; au++) begin
      for (int c = 3; c <= 8; c++) begin
        for (int inc = 1; inc <= 4; inc++) begin
          int m;
          wr(12'h240, 0);
          wr(12'h244, 1);
          wr(12'h100, 0); wr(12'h104, 0);
          wr(12'h200, c); wr(12'h204, 0); wr(12'h208, inc);
          wr(12'h240, 32'h101 | (au << 1));
          idle(20);
          wr(12'h240, 0);
          m = (20 - c) / inc + 1;
          rd(12'h200, d);
          chk($sformatf("R8 cmp au=%0d c=%0d inc=%0d", au, c, inc), d,
              (au != 0) ? c + inc * m : c);
          rd(12'h244, d);
          chk($sformatf("R6 status au=%0d c=%0d inc=%0d", au, c, inc), d, 1);
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule